// File: doc/BRIEF.md
# Add-on Card Interrupt and Register Bridge

This block is the host-side glue of an add-on controller card. A simple register bus reaches three separate windows, picked by one-hot window selects. The first window holds a single 32-bit interrupt control/status register. The second window passes byte accesses through to an attached peripheral port, but only within a limited offset range. The third window is a read-only identification window.

The peripheral raises a level interrupt. The bridge turns it into one registered host interrupt line, gated by an enable bit in the control/status register. Reading the register shows the live raw interrupt level in a status bit. When software changes the enable while a request is pending, the host line follows on the next clock.

Every access is a single-cycle `bus_wr` or `bus_rd` strobe with the address, the access width flag and a window select held for that cycle. Read data is combinational within the access cycle. Registers are little-endian: bit 0 of `bus_rdata` is bit 0 of the addressed register.

Top module: `irqb_top`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `host_irq` is 0, the control/status register reads 0 and `periph_rst` is 1. From the next clock on, `periph_rst` is 0.
- R2: In window 0 (`win_sel[0]`), the control/status register answers only a 32-bit access (`bus_word`=1) at offset 0x38. A write there stores the full word. A read there returns the stored word, with bit 23 replaced as R3 states. Every other offset, and every byte access, reads 0 and leaves the stored word unchanged.
- R3: Bit 23 of a control/status read always equals the current level of `periph_irq`, whatever was last written to that bit.
- R4: Bit 13 of the stored word is the interrupt enable. One clock after any change, `host_irq` equals `periph_irq` AND bit 13. It stays 0 while bit 13 is clear.
- R5: A control/status write that changes bit 13 while `periph_irq` is 1 drives `host_irq` to the written bit 13 on the next clock.
- R6: In window 1 (`win_sel[1]`), a byte access at an offset below 0x20 is forwarded. `periph_addr` carries the offset, `periph_wdata` carries `bus_wdata[7:0]`, and `periph_wr` or `periph_rd` pulses for the access cycle. A read returns `periph_rdata` in `bus_rdata[7:0]` with the upper bits 0, in the same cycle.
- R7: A window 1 access at an offset of 0x20 or above produces no `periph_wr` or `periph_rd` strobe and reads 0.
- R8: In window 2 (`win_sel[2]`), offset 7 reads 0xD0 (version 13 in the upper nibble, 0 in the lower nibble). The other offsets read 0, and writes change nothing that a later read shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_sel | input | 3 | One-hot window select: bit 0 control, bit 1 peripheral, bit 2 identification |
| bus_addr | input | 7 | Byte offset within the selected window |
| bus_word | input | 1 | 1 for a 32-bit access, 0 for a byte access |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| periph_irq | input | 1 | Level interrupt from the peripheral |
| host_irq | output | 1 | Registered host interrupt |
| periph_addr | output | 5 | Forwarded peripheral offset |
| periph_wdata | output | 8 | Forwarded write byte |
| periph_wr | output | 1 | Forwarded write strobe |
| periph_rd | output | 1 | Forwarded read strobe |
| periph_rdata | input | 8 | Peripheral read byte |
| periph_rst | output | 1 | Peripheral reset pulse |

## Verification
The interrupt path is exercised in three ways. The raw interrupt is toggled with the enable set and then cleared, which separates gating from plain pass-through. The enable is written while a request is pending, which tells an immediate update apart from one that waits for the next edge of the raw level. Register writes use values whose bit 13 and bit 23 differ from the live state, so stored bits can be distinguished from reflected ones. Peripheral accesses at 0x00, 0x1F, 0x20 and 0x7F bracket the forwarding limit, and word, byte and wrong-offset accesses probe the register decode.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
    localparam int WIN_AW     = 7;
    localparam int DATA_W     = 32;
    localparam int CSR_OFS    = 'h38;
    localparam int EN_BIT     = 13;
    localparam int STAT_BIT   = 23;
    localparam int FWD_LIMIT  = 'h20;
    localparam int PERIPH_AW  = $clog2(FWD_LIMIT);
    localparam int ID_SPAN    = 8;
    localparam int ID_OFS     = 7;
    localparam int ID_VERSION = 13;
    localparam int WIN_CTRL   = 0;
    localparam int WIN_PERIPH = 1;
    localparam int WIN_ID     = 2;
    localparam int NUM_WIN    = 3;

    typedef struct packed {
        logic [DATA_W-1:0] csr;
        logic              irq;
        logic              prst;
    } csr_state_t;
endpackage

// File: rtl/irqb_csr.sv
module irqb_csr
    import irqb_pkg::*;
#(
    parameter int AW    = WIN_AW,
    parameter int DW    = DATA_W,
    parameter int OFS   = CSR_OFS,
    parameter int ENB   = EN_BIT,
    parameter int STB   = STAT_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic [AW-1:0] addr,
    input  logic          word,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          raw_irq,
    output logic [DW-1:0] rdata,
    output logic          host_irq,
    output logic          periph_rst
);
    localparam logic [AW-1:0] OFS_A = AW'(OFS);

    csr_state_t st_d, st_q;
    logic hit, wr_hit;

    assign hit    = sel && word && (addr == OFS_A);
    assign wr_hit = hit && wr;

    always_comb begin
        st_d      = st_q;
        st_d.prst = 1'b0;
        if (wr_hit) begin
            st_d.csr = wdata;
        end
        st_d.irq = raw_irq && st_d.csr[ENB];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.csr  <= '0;
            st_q.irq  <= 1'b0;
            st_q.prst <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata      = st_q.csr;
            rdata[STB] = raw_irq;
        end
    end

    assign host_irq   = st_q.irq;
    assign periph_rst = st_q.prst;

    // R1: the peripheral reset lasts a single cycle after release
    p_reset_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        periph_rst |=> !periph_rst);
    // R4: masked while enable is clear
    p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.csr[ENB] && !wr_hit) |=> !host_irq);
    // R4: follows the raw level while enabled
    p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.csr[ENB] && !wr_hit) |=> (host_irq == $past(raw_irq)));
    // R5: an enable write with a pending request takes effect on the next clock
    p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && raw_irq) |=> (host_irq == $past(wdata[ENB])));
endmodule

// File: rtl/irqb_fwd.sv
module irqb_fwd
    import irqb_pkg::*;
#(
    parameter int AW    = WIN_AW,
    parameter int PAW   = PERIPH_AW,
    parameter int LIMIT = FWD_LIMIT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel,
    input  logic [AW-1:0]  addr,
    input  logic           wr,
    input  logic           rd,
    input  logic [7:0]     wdata,
    input  logic [7:0]     p_rdata,
    output logic [PAW-1:0] p_addr,
    output logic [7:0]     p_wdata,
    output logic           p_wr,
    output logic           p_rd,
    output logic [7:0]     rdata
);
    localparam logic [AW-1:0] LIM_A = AW'(LIMIT);

    logic in_range;

    assign in_range = sel && (addr < LIM_A);
    assign p_addr   = addr[PAW-1:0];
    assign p_wdata  = wdata;
    assign p_wr     = in_range && wr;
    assign p_rd     = in_range && rd;
    assign rdata    = in_range ? p_rdata : 8'h00;

    // R7: nothing reaches the port at or above the limit
    p_no_fwd_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= LIM_A) |-> (!p_wr && !p_rd));
    // R6: at most one strobe per access
    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr && rd)) |-> $onehot0({p_wr, p_rd}));
endmodule

// File: rtl/irqb_ident.sv
module irqb_ident
    import irqb_pkg::*;
#(
    parameter int AW   = WIN_AW,
    parameter int SPAN = ID_SPAN,
    parameter int OFS  = ID_OFS,
    parameter int VER  = ID_VERSION
) (
    input  logic          sel,
    input  logic [AW-1:0] addr,
    output logic [7:0]    rdata
);
    localparam logic [AW-1:0] OFS_A = AW'(OFS);
    localparam logic [7:0]    ID_VAL = {4'(VER), 4'h0};

    always_comb begin
        rdata = 8'h00;
        if (sel && (addr == OFS_A) && (OFS < SPAN)) begin
            rdata = ID_VAL;
        end
    end
endmodule

// File: rtl/irqb_top.sv
module irqb_top
    import irqb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WIN-1:0]   win_sel,
    input  logic [WIN_AW-1:0]    bus_addr,
    input  logic                 bus_word,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 periph_irq,
    output logic                 host_irq,
    output logic [PERIPH_AW-1:0] periph_addr,
    output logic [7:0]           periph_wdata,
    output logic                 periph_wr,
    output logic                 periph_rd,
    input  logic [7:0]           periph_rdata,
    output logic                 periph_rst
);
    logic [DATA_W-1:0] csr_rd;
    logic [7:0]        fwd_rd;
    logic [7:0]        id_rd;

    irqb_csr u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (win_sel[WIN_CTRL]),
        .addr       (bus_addr),
        .word       (bus_word),
        .wr         (bus_wr),
        .wdata      (bus_wdata),
        .raw_irq    (periph_irq),
        .rdata      (csr_rd),
        .host_irq   (host_irq),
        .periph_rst (periph_rst)
    );

    irqb_fwd u_fwd (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (win_sel[WIN_PERIPH]),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wdata   (bus_wdata[7:0]),
        .p_rdata (periph_rdata),
        .p_addr  (periph_addr),
        .p_wdata (periph_wdata),
        .p_wr    (periph_wr),
        .p_rd    (periph_rd),
        .rdata   (fwd_rd)
    );

    irqb_ident u_id (
        .sel   (win_sel[WIN_ID]),
        .addr  (bus_addr),
        .rdata (id_rd)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (1'b1)
            win_sel[WIN_CTRL]:   bus_rdata = csr_rd;
            win_sel[WIN_PERIPH]: bus_rdata = {{(DATA_W-8){1'b0}}, fwd_rd};
            win_sel[WIN_ID]:     bus_rdata = {{(DATA_W-8){1'b0}}, id_rd};
            default:             bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/irqb_top_tb.sv
module irqb_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  win_sel = '0;
    logic [6:0]  bus_addr = '0;
    logic        bus_word = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        periph_irq = 1'b0;
    logic        host_irq;
    logic [4:0]  periph_addr;
    logic [7:0]  periph_wdata;
    logic        periph_wr, periph_rd;
    logic [7:0]  periph_rdata;
    logic        periph_rst;

    int tests = 0, fails = 0;
    bit done = 0;
    bit model_on = 0;

    // reference state
    logic [31:0] m_csr = '0;
    logic        m_irq = 1'b0;

    always #5 clk = ~clk;

    // mock peripheral: read data depends on address
    assign periph_rdata = {3'b101, periph_addr} ^ 8'h3C;

    irqb_top u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural model, clocked
    always @(posedge clk) begin
        if (!rst_n) begin
            m_csr <= '0;
            m_irq <= 1'b0;
        end else begin
            logic [31:0] nc;
            nc = m_csr;
            if (win_sel == 3'b001 && bus_word && bus_wr && bus_addr == 7'h38) nc = bus_wdata;
            m_csr <= nc;
            m_irq <= periph_irq & nc[13];
        end
    end

    // per-clock comparison of the interrupt line (R4, R5)
    always @(negedge clk) begin
        if (model_on) chk("R4/R5 host_irq", {31'b0, host_irq}, {31'b0, m_irq});
    end

    task automatic acc(input logic [2:0] w, input logic [6:0] a, input logic word,
                       input logic wr, input logic [31:0] wd,
                       output logic [31:0] rd, output logic pw, output logic pr);
        @(negedge clk);
        win_sel = w; bus_addr = a; bus_word = word;
        bus_wr = wr; bus_rd = !wr; bus_wdata = wd;
        #1;
        rd = bus_rdata; pw = periph_wr; pr = periph_rd;
        @(posedge clk);
        #1;
        win_sel = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_word = 1'b0;
    endtask

    function automatic logic [31:0] exp_csr_read();
        logic [31:0] v;
        v = m_csr;
        v[23] = periph_irq;
        return v;
    endfunction

    task automatic set_irq(input logic v);
        @(negedge clk);
        periph_irq = v;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        logic pw, pr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: first cycle after release
        chk("R1 periph_rst", {31'b0, periph_rst}, 32'd1);
        chk("R1 host_irq", {31'b0, host_irq}, 32'd0);
        model_on = 1;
        acc(3'b001, 7'h38, 1, 0, 0, rd, pw, pr);
        chk("R1 csr reset", rd, 32'd0);
        chk("R1 periph_rst cleared", {31'b0, periph_rst}, 32'd0);

        // R2: store and read back
        acc(3'b001, 7'h38, 1, 1, 32'h1234_5678, rd, pw, pr);
        acc(3'b001, 7'h38, 1, 0, 0, rd, pw, pr);
        chk("R2 readback", rd, exp_csr_read());
        acc(3'b001, 7'h38, 0, 1, 32'hFFFF_FFFF, rd, pw, pr);
        acc(3'b001, 7'h3C, 1, 1, 32'hFFFF_FFFF, rd, pw, pr);
        acc(3'b001, 7'h3C, 1, 0, 0, rd, pw, pr);
        chk("R2 other offset zero", rd, 32'd0);
        acc(3'b001, 7'h38, 0, 0, 0, rd, pw, pr);
        chk("R2 byte read zero", rd, 32'd0);
        acc(3'b001, 7'h38, 1, 0, 0, rd, pw, pr);
        chk("R2 stored unchanged", rd, 32'h1234_5678);

        // R3: live status bit, written bit 23 ignored on read
        acc(3'b001, 7'h38, 1, 1, 32'h0080_0000, rd, pw, pr);
        acc(3'b001, 7'h38, 1, 0, 0, rd, pw, pr);
        chk("R3 status low", {31'b0, rd[23]}, 32'd0);
        set_irq(1);
        acc(3'b001, 7'h38, 1, 0, 0, rd, pw, pr);
        chk("R3 status high", {31'b0, rd[23]}, 32'd1);
        chk("R4 disabled stays low", {31'b0, host_irq}, 32'd0);

        // R5: enable while pending, then disable while pending
        acc(3'b001, 7'h38, 1, 1, 32'h0000_2000, rd, pw, pr);
        #4;
        chk("R5 enable pending", {31'b0, host_irq}, 32'd1);
        acc(3'b001, 7'h38, 1, 1, 32'h0000_0000, rd, pw, pr);
        #4;
        chk("R5 disable pending", {31'b0, host_irq}, 32'd0);

        // R4: follow raw level while enabled
        acc(3'b001, 7'h38, 1, 1, 32'h0000_2000, rd, pw, pr);
        set_irq(0);
        chk("R4 follow low", {31'b0, host_irq}, 32'd0);
        set_irq(1);
        chk("R4 follow high", {31'b0, host_irq}, 32'd1);
        acc(3'b001, 7'h38, 1, 0, 0, rd, pw, pr);
        chk("R3 status with enable", rd, 32'h0080_2000);
        set_irq(0);

        // R6: forwarded peripheral accesses
        acc(3'b010, 7'h05, 0, 1, 32'h0000_00A7, rd, pw, pr);
        chk("R6 write strobe", {30'b0, pw, pr}, 32'd2);
        acc(3'b010, 7'h1F, 0, 0, 0, rd, pw, pr);
        chk("R6 read strobe", {30'b0, pw, pr}, 32'd1);
        chk("R6 read data", rd, {24'b0, ({3'b101, 5'h1F} ^ 8'h3C)});
        acc(3'b010, 7'h00, 0, 0, 0, rd, pw, pr);
        chk("R6 read data 0", rd, {24'b0, ({3'b101, 5'h00} ^ 8'h3C)});

        // R7: dropped above the limit
        acc(3'b010, 7'h20, 0, 1, 32'h55, rd, pw, pr);
        chk("R7 no write strobe", {30'b0, pw, pr}, 32'd0);
        acc(3'b010, 7'h7F, 0, 0, 0, rd, pw, pr);
        chk("R7 no read strobe", {30'b0, pw, pr}, 32'd0);
        chk("R7 read zero", rd, 32'd0);

        // R8: identification
        acc(3'b100, 7'h07, 0, 0, 0, rd, pw, pr);
        chk("R8 version", rd, 32'h0000_00D0);
        acc(3'b100, 7'h03, 0, 0, 0, rd, pw, pr);
        chk("R8 other zero", rd, 32'd0);
        acc(3'b100, 7'h07, 0, 1, 32'hFF, rd, pw, pr);
        acc(3'b100, 7'h07, 0, 0, 0, rd, pw, pr);
        chk("R8 write ignored", rd, 32'h0000_00D0);

        repeat (2) @(negedge clk);
        model_on = 0;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule